// File: doc/BRIEF.md
# Video Sync Timing Measurement Unit

This block observes the horizontal sync, vertical sync and data-enable levels of an incoming video stream. From the sync and data-enable edges it derives eight timing intervals. On the vertical axis it measures sync width, back porch, active height and front porch, counted in lines. On the horizontal axis it measures the same four intervals in clock cycles. The three video inputs pass through a two-flop synchronizer and are sampled on the block clock. Each sync input has a programmable polarity. Each stored interval can raise an interrupt when its value changes.

Software reaches the block through a simple synchronous register port. That port holds the stored intervals, a control word, a per-interval trigger mask, the interrupt status and a status word. It also holds a programmable limit for how long horizontal sync may stay inactive before the block flags sync loss. The results are normally refreshed once per frame. A control bit can instead refresh the horizontal results at the end of every line.

Top module: `vtm_top`

## Requirements
- R1: After reset, control (0x24) reads 0, trigger mask (0x28) reads 0xFF, timeout limit (0x2C) reads 0x1FFF, interrupt status (0x00) and status (0x30) read 0, and `irq_o` is low.
- R2: Horizontal intervals are counted in clock cycles. Sync (0x14) runs from the active edge of hsync to its inactive edge. Back porch (0x18) runs from there to the data-enable rising edge. Active (0x1C) is the data-enable high time. Front porch (0x20) runs from the data-enable falling edge to the next active hsync edge.
- R3: Vertical intervals are counted in lines, one per active hsync edge, with vsync edges aligned to an active hsync edge. Sync (0x04) is the number of lines with vsync active. Back porch (0x08) is the number of lines before the first line with data enable. Active (0x0C) is the number of lines with data enable. Front porch (0x10) is the number of lines from there to the next active vsync edge.
- R4: Control bit 0 set makes hsync active low, and control bit 1 set makes vsync active low.
- R5: With control bit 2 (measure enable) set, all stored intervals are refreshed at each active vsync edge that closes a frame which began after enable. The horizontal values come from the last line of that frame that contained data enable.
- R6: With control bit 4 set, the horizontal intervals are also refreshed at each active hsync edge that ends a line containing data enable. With bit 4 clear, such lines leave the stored values unchanged until the next vsync.
- R7: When a stored interval is refreshed with a value different from the one it held, and the matching trigger-mask bit is set, the matching interrupt status bit is set. Bits 0..3 are vertical sync, back porch, active and front porch, and bits 4..7 are the horizontal ones in the same order. An unchanged refresh sets nothing.
- R8: Writing 1 to an interrupt status bit clears it, and writing 0 leaves it unchanged.
- R9: `irq_o` is high exactly when control bit 3 is set and any interrupt status bit is set.
- R10: Status bit 1 is set once the first complete frame after enable has been stored. Clearing control bit 2 clears status bit 1 and restarts all counting.
- R11: While measuring, status bit 0 is set when hsync stays inactive for more than the timeout limit (0x2C) in clock cycles. It clears at the next active hsync edge.
- R12: A write of zero to the timeout limit is ignored.
- R13: `reg_rdata` returns the register addressed in the previous cycle. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; video inputs are sampled on it |
| rst_n | input | 1 | Synchronous active-low reset |
| vid_hs | input | 1 | Raw horizontal sync |
| vid_vs | input | 1 | Raw vertical sync |
| vid_de | input | 1 | Raw data enable, active high |
| reg_addr | input | AW | Byte address of the register to access |
| reg_wen | input | 1 | Write strobe for `reg_addr` |
| reg_wdata | input | RW | Write data |
| reg_rdata | output | RW | Read data for the previous cycle's address |
| irq_o | output | 1 | Level interrupt request |

## Verification
A raw video edge reaches the synchronizer output after two clock edges. Edge detection and interval capture take one more edge, and the result register is updated on the edge after that. A stored value is therefore readable on the fifth edge after the raw edge that closes its line or frame, and the interrupt status bit appears in the same cycle as the stored value. The bench reads results only after the whole line or frame sequence has been driven, followed by idle cycles that leave every interval unchanged. The timeout flag is sampled well before and well after the programmed limit, so the two-cycle synchronizer delay cannot move a result across the sampling point. Register reads are sampled on the falling edge after the edge that registers `reg_rdata`.

// File: rtl/vtm_pkg.sv
// Shared constants for the video timing measurement unit: register byte
// offsets, control bit positions and interval count. Assumes a 6-bit
// byte address with word-aligned accesses.
package vtm_pkg;
    localparam int NUM_IV    = 8;      // four vertical then four horizontal intervals
    localparam int OFS_IRQ   = 'h00;
    localparam int OFS_MEAS0 = 'h04;
    localparam int OFS_CTL   = 'h24;
    localparam int OFS_TRIG  = 'h28;
    localparam int OFS_TMO   = 'h2C;
    localparam int OFS_STAT  = 'h30;
    localparam int CB_HPOL   = 0;
    localparam int CB_VPOL   = 1;
    localparam int CB_EN     = 2;
    localparam int CB_IEN    = 3;
    localparam int CB_UPDH   = 4;
    localparam int CTL_W     = 5;
    localparam int TMO_RST   = 'h1FFF;
endpackage

// File: rtl/vtm_sync.sv
// Two-flop level synchronizer for W independent single-bit inputs.
// Assumes each input is a slowly changing level (no pulse shorter than a clock).
module vtm_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] meta_q;

    // Two register stages per bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            dout   <= '0;
        end else begin
            meta_q <= din;
            dout   <= meta_q;
        end
    end
endmodule

// File: rtl/vtm_interval.sv
// Interval timer: time-stamps sync and data-enable edges within a line
// (clock cycles) and within a frame (lines), then converts the stamps into
// eight interval lengths. Assumes polarity-corrected, synchronized inputs,
// and vsync edges that coincide with an active hsync edge.
module vtm_interval
    import vtm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          en,
    input  logic                          hs,
    input  logic                          vs,
    input  logic                          de,
    output logic [NUM_IV-1:0][CNT_W-1:0]  meas,
    output logic                          line_done,
    output logic                          frame_done
);
    logic hs_d, vs_d, de_d;
    logic hs_r, hs_f, vs_r, vs_f, de_r, de_f;
    logic [CNT_W-1:0] hcnt, st_hf, st_dr, st_df;
    logic [CNT_W-1:0] vcnt, st_vf, st_vdr, st_vdf;
    logic line_go, line_de, frm_go, frm_de;
    logic [3:0][CNT_W-1:0] h_meas, v_meas;

    // One-cycle history of each level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_d <= 1'b0; vs_d <= 1'b0; de_d <= 1'b0;
        end else begin
            hs_d <= hs; vs_d <= vs; de_d <= de;
        end
    end

    assign hs_r = hs & ~hs_d;
    assign hs_f = ~hs & hs_d;
    assign vs_r = vs & ~vs_d;
    assign vs_f = ~vs & vs_d;
    assign de_r = de & ~de_d;
    assign de_f = ~de & de_d;

    // Horizontal counter, edge stamps and per-line interval capture
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            hcnt <= '0; st_hf <= '0; st_dr <= '0; st_df <= '0;
            line_go <= 1'b0; line_de <= 1'b0; line_done <= 1'b0;
            h_meas <= '0;
        end else begin
            line_done <= 1'b0;
            hcnt      <= hs_r ? CNT_W'(1) : hcnt + 1'b1;
            if (hs_f) st_hf <= hcnt;
            if (de_r) begin
                st_dr   <= hcnt;
                line_de <= 1'b1;
            end
            if (de_f) st_df <= hcnt;
            if (hs_r) begin
                line_go <= 1'b1;
                line_de <= 1'b0;
                if (line_go && line_de) begin
                    h_meas[0] <= st_hf;
                    h_meas[1] <= st_dr - st_hf;
                    h_meas[2] <= st_df - st_dr;
                    h_meas[3] <= hcnt - st_df;
                    line_done <= 1'b1;
                end
            end
        end
    end

    // Line counter, frame stamps and per-frame interval capture
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            vcnt <= '0; st_vf <= '0; st_vdr <= '0; st_vdf <= '0;
            frm_go <= 1'b0; frm_de <= 1'b0; frame_done <= 1'b0;
            v_meas <= '0;
        end else begin
            frame_done <= 1'b0;
            if (vs_r)      vcnt <= hs_r ? CNT_W'(1) : '0;
            else if (hs_r) vcnt <= vcnt + 1'b1;
            if (vs_f) st_vf <= vcnt;
            if (de_r && !frm_de) begin
                st_vdr <= vcnt - 1'b1;
                frm_de <= 1'b1;
            end
            if (de_f) st_vdf <= vcnt;
            if (vs_r) begin
                frm_go <= 1'b1;
                frm_de <= 1'b0;
                if (frm_go && frm_de) begin
                    v_meas[0]  <= st_vf;
                    v_meas[1]  <= st_vdr - st_vf;
                    v_meas[2]  <= st_vdf - st_vdr;
                    v_meas[3]  <= vcnt - st_vdf;
                    frame_done <= 1'b1;
                end
            end
        end
    end

    assign meas = {h_meas, v_meas};
endmodule

// File: rtl/vtm_watchdog.sv
// Sync-loss watchdog: counts clock cycles with hsync inactive and flags a
// timeout once the count reaches the limit. Assumes a nonzero limit.
module vtm_watchdog #(
    parameter int TW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          hs,
    input  logic [TW-1:0] limit,
    output logic          tmo
);
    logic [TW-1:0] cnt;
    logic          hs_d;

    // Saturating inactive-time counter and sticky flag cleared by an hsync rise
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt  <= '0;
            hs_d <= 1'b0;
            tmo  <= 1'b0;
        end else begin
            hs_d <= hs;
            if (hs)             cnt <= '0;
            else if (~&cnt)     cnt <= cnt + 1'b1;
            if (hs && !hs_d)    tmo <= 1'b0;
            else if (!hs && cnt >= limit) tmo <= 1'b1;
        end
    end
endmodule

// File: rtl/vtm_regs.sv
// Register file: control, trigger mask, timeout limit, stored results with
// change detection, sticky interrupt status and registered read mux.
// Assumes word-aligned byte addresses.
module vtm_regs
    import vtm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int RW    = 32,
    parameter int AW    = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [AW-1:0]                 addr,
    input  logic                          wen,
    input  logic [RW-1:0]                 wdata,
    output logic [RW-1:0]                 rdata,
    input  logic [NUM_IV-1:0][CNT_W-1:0]  meas,
    input  logic                          line_done,
    input  logic                          frame_done,
    input  logic                          tmo,
    output logic [CTL_W-1:0]              ctl,
    output logic [RW-1:0]                 tmo_lim,
    output logic [NUM_IV-1:0]             irq_sts,
    output logic                          init_done,
    output logic                          irq_o
);
    logic [NUM_IV-1:0]            trig, upd, hit, w1c;
    logic [NUM_IV-1:0][CNT_W-1:0] res;
    logic [RW-1:0]                rd_nxt;

    assign upd = {{(NUM_IV/2){frame_done | (line_done & ctl[CB_UPDH])}},
                  {(NUM_IV/2){frame_done}}};
    assign w1c = (wen && addr == AW'(OFS_IRQ)) ? wdata[NUM_IV-1:0] : '0;

    // Per-interval result storage and change detection
    for (genvar i = 0; i < NUM_IV; i++) begin : g_iv
        assign hit[i] = upd[i] & trig[i] & (meas[i] != res[i]);
        always_ff @(posedge clk) begin
            if (!rst_n)      res[i] <= '0;
            else if (upd[i]) res[i] <= meas[i];
        end
    end

    // Software-writable configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl     <= '0;
            trig    <= '1;
            tmo_lim <= RW'(TMO_RST);
        end else if (wen) begin
            if (addr == AW'(OFS_CTL))  ctl  <= wdata[CTL_W-1:0];
            if (addr == AW'(OFS_TRIG)) trig <= wdata[NUM_IV-1:0];
            if (addr == AW'(OFS_TMO) && wdata != '0) tmo_lim <= wdata;
        end
    end

    // Sticky interrupt status (set wins over clear) and init-done flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_sts   <= '0;
            init_done <= 1'b0;
        end else begin
            irq_sts <= (irq_sts & ~w1c) | hit;
            if (!ctl[CB_EN])    init_done <= 1'b0;
            else if (frame_done) init_done <= 1'b1;
        end
    end

    // Read mux for the addressed register
    always_comb begin
        rd_nxt = '0;
        if (addr == AW'(OFS_IRQ))  rd_nxt = RW'(irq_sts);
        if (addr == AW'(OFS_CTL))  rd_nxt = RW'(ctl);
        if (addr == AW'(OFS_TRIG)) rd_nxt = RW'(trig);
        if (addr == AW'(OFS_TMO))  rd_nxt = tmo_lim;
        if (addr == AW'(OFS_STAT)) rd_nxt = RW'({init_done, tmo});
        for (int i = 0; i < NUM_IV; i++)
            if (addr == AW'(OFS_MEAS0 + 4 * i)) rd_nxt = RW'(res[i]);
    end

    // Registered read data
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= rd_nxt;
    end

    assign irq_o = ctl[CB_IEN] & (|irq_sts);
endmodule

// File: rtl/vtm_top.sv
// Top of the video timing measurement unit: synchronizes the video inputs,
// applies sync polarity, and connects the interval timer, the watchdog and
// the register file. Assumes one clock for video sampling and register access.
module vtm_top
    import vtm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int RW    = 32,
    parameter int AW    = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vid_hs,
    input  logic          vid_vs,
    input  logic          vid_de,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_wen,
    input  logic [RW-1:0] reg_wdata,
    output logic [RW-1:0] reg_rdata,
    output logic          irq_o
);
    logic [2:0]                   sync_s;
    logic                         hs_c, vs_c, de_c;
    logic [CTL_W-1:0]             ctl_q;
    logic [RW-1:0]                tmo_lim;
    logic [NUM_IV-1:0][CNT_W-1:0] meas;
    logic [NUM_IV-1:0]            irq_sts;
    logic                         line_done, frame_done, tmo_flag, init_done, upd_any;

    vtm_sync #(.W(3)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .din({vid_de, vid_vs, vid_hs}), .dout(sync_s)
    );

    assign hs_c    = sync_s[0] ^ ctl_q[CB_HPOL];
    assign vs_c    = sync_s[1] ^ ctl_q[CB_VPOL];
    assign de_c    = sync_s[2];
    assign upd_any = line_done | frame_done;

    vtm_interval #(.CNT_W(CNT_W)) u_iv (
        .clk(clk), .rst_n(rst_n), .en(ctl_q[CB_EN]),
        .hs(hs_c), .vs(vs_c), .de(de_c),
        .meas(meas), .line_done(line_done), .frame_done(frame_done)
    );

    vtm_watchdog #(.TW(RW)) u_wd (
        .clk(clk), .rst_n(rst_n), .en(ctl_q[CB_EN]),
        .hs(hs_c), .limit(tmo_lim), .tmo(tmo_flag)
    );

    vtm_regs #(.CNT_W(CNT_W), .RW(RW), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .addr(reg_addr), .wen(reg_wen), .wdata(reg_wdata), .rdata(reg_rdata),
        .meas(meas), .line_done(line_done), .frame_done(frame_done),
        .tmo(tmo_flag), .ctl(ctl_q), .tmo_lim(tmo_lim),
        .irq_sts(irq_sts), .init_done(init_done), .irq_o(irq_o)
    );
endmodule

// File: rtl/vtm_chk.sv
// Assertion checker for vtm_top, attached by the bind statement below.
module vtm_chk
    import vtm_pkg::*;
#(
    parameter int RW = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_o,
    input logic [CTL_W-1:0]  ctl,
    input logic              init_done,
    input logic              tmo,
    input logic [RW-1:0]     tmo_lim,
    input logic              hs,
    input logic              upd_any,
    input logic [NUM_IV-1:0] irq_sts
);
    // R12
    tmo_lim_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_lim != '0);

    // R7
    sts_set_on_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(irq_sts & ~$past(irq_sts))) |-> $past(upd_any));

    // R9
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl[CB_IEN] |-> !irq_o);

    // R10
    init_drop_on_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(init_done) |-> $past(!ctl[CB_EN]));

    // R10
    init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl[CB_EN] |=> !init_done);

    // R11
    tmo_rise_inactive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo) |-> $past(!hs && ctl[CB_EN]));
endmodule

bind vtm_top vtm_chk #(.RW(RW)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .ctl(ctl_q),
    .init_done(init_done), .tmo(tmo_flag), .tmo_lim(tmo_lim),
    .hs(hs_c), .upd_any(upd_any), .irq_sts(irq_sts)
);

// File: tb/vtm_top_tb_top.sv
module vtm_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hs_r = 1'b0, vs_r = 1'b0, de_r = 1'b0;
    logic [5:0]  addr = '0;
    logic        wen = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    int n_chk = 0, n_err = 0;
    int hw[4], vw[4], pv[8];
    bit hpol = 0, vpol = 0;
    logic [7:0] trig, exp_sts;
    logic [31:0] rv;

    always #5 clk = ~clk;

    vtm_top dut_i (
        .clk(clk), .rst_n(rst_n), .vid_hs(hs_r), .vid_vs(vs_r), .vid_de(de_r),
        .reg_addr(addr), .reg_wen(wen), .reg_wdata(wdata), .reg_rdata(rdata), .irq_o(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; wen = 1'b0;
        @(negedge clk); d = rdata;
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; wen = 1'b1;
        @(negedge clk); wen = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk); hs_r = hpol; vs_r = vpol; de_r = 1'b0;
    endtask

    task automatic line(input bit vact, input bit de_on);
        int tot = hw[0] + hw[1] + hw[2] + hw[3];
        for (int x = 0; x < tot; x++) begin
            @(negedge clk);
            hs_r = (x < hw[0]) ^ hpol;
            vs_r = vact ^ vpol;
            de_r = de_on && (x >= hw[0] + hw[1]) && (x < hw[0] + hw[1] + hw[2]);
        end
    endtask

    task automatic frames(input int n);
        int tot = vw[0] + vw[1] + vw[2] + vw[3];
        for (int f = 0; f < n; f++)
            for (int y = 0; y < tot; y++)
                line(y < vw[0], (y >= vw[0] + vw[1]) && (y < vw[0] + vw[1] + vw[2]));
        idle();
    endtask

    function automatic int expv(input int i);
        return (i < 4) ? vw[i] : hw[i - 4];
    endfunction

    function automatic logic [7:0] chg(input logic [7:0] m);
        logic [7:0] s = '0;
        for (int i = 0; i < 8; i++) s[i] = m[i] && (expv(i) != pv[i]);
        return s;
    endfunction

    task automatic chk_meas(input string tag);
        for (int i = 0; i < 8; i++) begin
            rd(6'(4 + 4 * i), rv);
            chk($sformatf("%s interval %0d", tag, i), rv, 32'(expv(i)));
        end
    endtask

    task automatic save_prev();
        for (int i = 0; i < 8; i++) pv[i] = expv(i);
    endtask

    function automatic logic [31:0] polw();
        return {30'd0, vpol, hpol};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_err++; n_chk++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 8; i++) pv[i] = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        rd(6'h24, rv); chk("R1 control", rv, 0);
        rd(6'h28, rv); chk("R1 trigger mask", rv, 32'hFF);
        rd(6'h2C, rv); chk("R1 timeout limit", rv, 32'h1FFF);
        rd(6'h00, rv); chk("R1 irq status", rv, 0);
        rd(6'h30, rv); chk("R1 status", rv, 0);
        chk("R1 irq_o", {31'd0, irq}, 0);

        // Random configurations with random polarities (R2 R3 R4 R5 R7 R9 R10)
        for (int c = 0; c < 6; c++) begin
            wr(6'h24, polw());
            hpol = 1'($urandom_range(0, 1)); vpol = 1'($urandom_range(0, 1));
            hw[0] = $urandom_range(1, 6); hw[1] = $urandom_range(1, 6);
            hw[2] = $urandom_range(4, 16); hw[3] = $urandom_range(1, 6);
            vw[0] = $urandom_range(1, 3); vw[1] = $urandom_range(1, 3);
            vw[2] = $urandom_range(2, 8); vw[3] = $urandom_range(1, 3);
            trig = (c == 0) ? 8'hFF : 8'($urandom_range(0, 255));
            idle(); repeat (4) @(negedge clk);
            wr(6'h00, 32'hFF);
            wr(6'h28, {24'd0, trig});
            rd(6'h30, rv); chk("R10 init clear while disabled", rv & 2, 0);
            wr(6'h24, polw() | 32'h0C);
            frames(1);
            rd(6'h30, rv); chk("R10 no init after one vsync", rv & 2, 0);
            frames(2);
            chk_meas($sformatf("R2 R3 R4 R5 cfg %0d", c));
            rd(6'h30, rv); chk("R10 init after full frame", rv & 2, 2);
            exp_sts = chg(trig);
            rd(6'h00, rv); chk("R7 change status", rv, {24'd0, exp_sts});
            chk("R9 irq_o", {31'd0, irq}, {31'd0, |exp_sts});
            save_prev();
        end

        // All intervals change with full mask, then write-1-clear (R7 R8 R9)
        for (int i = 0; i < 4; i++) begin hw[i]++; vw[i]++; end
        wr(6'h00, 32'hFF); wr(6'h28, 32'hFF);
        frames(3);
        chk_meas("R2 R3 directed");
        rd(6'h00, rv); chk("R7 all changed", rv, 32'hFF);
        wr(6'h00, 32'h0F);
        rd(6'h00, rv); chk("R8 partial clear", rv, 32'hF0);
        chk("R9 irq_o with bits", {31'd0, irq}, 1);
        wr(6'h00, 32'hF0);
        rd(6'h00, rv); chk("R8 full clear", rv, 0);
        chk("R9 irq_o no bits", {31'd0, irq}, 0);
        save_prev();

        // Unchanged frames set nothing (R7)
        frames(2);
        rd(6'h00, rv); chk("R7 no change no status", rv, 0);

        // Horizontal-only change with interrupt output disabled (R7 R9)
        wr(6'h24, polw() | 32'h04);
        for (int i = 0; i < 4; i++) hw[i]++;
        frames(3);
        rd(6'h00, rv); chk("R7 horizontal bits only", rv, 32'hF0);
        chk("R9 irq_o gated off", {31'd0, irq}, 0);
        save_prev();

        // Update on hsync (R6)
        wr(6'h24, polw() | 32'h14);
        for (int i = 0; i < 4; i++) hw[i]++;
        for (int k = 0; k < 3; k++) line(1'b0, 1'b1);
        idle();
        chk_meas("R6 hsync update");
        save_prev();
        wr(6'h24, polw() | 32'h04);
        for (int i = 0; i < 4; i++) hw[i]++;
        for (int k = 0; k < 3; k++) line(1'b0, 1'b1);
        idle();
        for (int i = 4; i < 8; i++) begin
            rd(6'(4 + 4 * i), rv);
            chk("R6 no hsync update when clear", rv, 32'(pv[i]));
        end

        // Disable clears init done (R10)
        wr(6'h24, polw());
        rd(6'h30, rv); chk("R10 disable clears init", rv & 2, 0);

        // Timeout limit and sync-loss flag (R11 R12 R13)
        wr(6'h2C, 0);
        rd(6'h2C, rv); chk("R12 zero write ignored", rv, 32'h1FFF);
        wr(6'h2C, 24);
        rd(6'h2C, rv); chk("R13 limit readback", rv, 24);
        wr(6'h24, polw() | 32'h04);
        rd(6'h24, rv); chk("R13 control readback", rv, polw() | 32'h04);
        for (int k = 0; k < 4; k++) begin @(negedge clk); hs_r = ~hpol; end
        @(negedge clk); hs_r = hpol;
        repeat (16) @(negedge clk);
        rd(6'h30, rv); chk("R11 no timeout below limit", rv & 1, 0);
        repeat (20) @(negedge clk);
        rd(6'h30, rv); chk("R11 timeout above limit", rv & 1, 1);
        for (int k = 0; k < 3; k++) begin @(negedge clk); hs_r = ~hpol; end
        @(negedge clk); hs_r = hpol;
        repeat (4) @(negedge clk);
        rd(6'h30, rv); chk("R11 cleared by hsync edge", rv & 1, 0);
        rd(6'h34, rv); chk("R13 unmapped reads zero", rv, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule